// File: doc/BRIEF.md
# Chain-Position Address Assignment Slave

This controller sits in each of a row of identical slave devices that share one serial bus with a master. The devices are wired in a chain: each one receives an enable from its upstream neighbour and drives an enable to its downstream neighbour. A slave without an address keeps its downstream enable low. The chain therefore stops at the first unnumbered device, and only that device can take the next address from the master. Once it holds a nonzero address, it opens the chain one clock later. The next device then becomes the only candidate, and the sequence repeats until the whole row is numbered.

The master sends a broadcast clear to return every slave to the unassigned state and restart numbering. Address zero means "unassigned". An assignment strobe that carries zero does nothing, and so does any strobe that reaches a slave which already holds an address.

After numbering finishes, the master leaves the assignment phase. A numbered slave may then raise its interrupt request when it has a local event pending.

Top module: `chain_addr_slave`

## Requirements
- R1: After reset, the address is 0, the downstream enable `pass_en` is 0 and `irq_req` is 0.
- R2: A `clr_all` strobe sets the address to 0 and `pass_en` to 0 at the next clock edge. `clr_all` takes priority over a simultaneous assignment.
- R3: When `assign_stb` is high, `chain_in` is high, the address is 0 and `assign_val` is nonzero, the address takes `assign_val` at that clock edge.
- R4: An assignment strobe while `chain_in` is low leaves the address unchanged.
- R5: An assignment strobe whose `assign_val` is 0 leaves the address unchanged.
- R6: A slave with a nonzero address ignores every assignment strobe until the next `clr_all`.
- R7: `pass_en` is registered. It is high exactly when, at the previous clock edge, the address was nonzero, `chain_in` was high and `clr_all` was low. It therefore rises one clock after the address is written.
- R8: `bus_on` follows `chain_in`: a slave is attached to the bus exactly when its upstream enable is high.
- R9: `irq_req` is high only when `evt_pend` is high, the address is nonzero and `enum_phase` is low.
- R10: With 30 slaves chained, each `chain_in` fed from the upstream `pass_en` and the first fed constant high, successive nonzero assignments number the slaves strictly in chain order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chain_in | input | 1 | Enable from the upstream neighbour, or from the master for the first slave |
| clr_all | input | 1 | Decoded broadcast strobe that clears all addresses |
| assign_stb | input | 1 | Decoded strobe from the master carrying a new address |
| assign_val | input | ADDR_W | Address value carried by the assignment strobe |
| enum_phase | input | 1 | High while the master is running the assignment phase |
| evt_pend | input | 1 | Local interrupt event pending |
| my_addr | output | ADDR_W | Current address; 0 means unassigned |
| bus_on | output | 1 | Slave is attached to the bus |
| pass_en | output | 1 | Enable to the downstream neighbour |
| irq_req | output | 1 | Interrupt request to the master |

## Verification
The bench builds a chain of 30 instances with the default 5-bit address width. This gives up to 31 nonzero values, enough for every slave, and lets the bench watch the enable ripple down the chain through registered hops. Random strobes mix zero values, repeated assignments and occasional broadcast clears. These drive the chain into partial numbering, full numbering and restart, and a bench model predicts the result for every slave. A directed pass numbers the slaves 1 through 30 in order and checks the chain-order rule, including a strobe that arrives after the last slave is already numbered.

// File: rtl/chain_addr_slave.sv
module chain_addr_slave #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain_in,
  input  logic              clr_all,
  input  logic              assign_stb,
  input  logic [ADDR_W-1:0] assign_val,
  input  logic              enum_phase,
  input  logic              evt_pend,
  output logic [ADDR_W-1:0] my_addr,
  output logic              bus_on,
  output logic              pass_en,
  output logic              irq_req
);

  localparam logic [ADDR_W-1:0] UNSET = '0;

  logic have_addr;
  logic take;

  assign have_addr = (my_addr != UNSET);
  assign take      = assign_stb && chain_in && !have_addr && (assign_val != UNSET);
  assign bus_on    = chain_in;
  assign irq_req   = evt_pend && have_addr && !enum_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      my_addr <= UNSET;
      pass_en <= 1'b0;
    end else begin
      if (clr_all)   my_addr <= UNSET;
      else if (take) my_addr <= assign_val;
      pass_en <= !clr_all && have_addr && chain_in;
    end
  end

  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (my_addr == UNSET) && !pass_en);

  a_r4_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_in && !clr_all) |=> $stable(my_addr));

  a_r5_zero_val: assert property (@(posedge clk) disable iff (!rst_n)
    (assign_stb && assign_val == UNSET && !clr_all) |=> $stable(my_addr));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (my_addr != UNSET && !clr_all) |=> $stable(my_addr));

  a_r7_pass_needs_addr: assert property (@(posedge clk) disable iff (!rst_n)
    pass_en |-> (my_addr != UNSET));

  a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (my_addr != UNSET) && !enum_phase);

endmodule

// File: tb/test_chain_addr_slave.sv
module test_chain_addr_slave;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 5;
  localparam int NSLV   = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_all = 1'b0, assign_stb = 1'b0, enum_phase = 1'b0;
  logic [ADDR_W-1:0] assign_val = '0;
  logic [NSLV-1:0] evt = '0;
  logic [NSLV-1:0] chain, pass, bus, irq;
  logic [ADDR_W-1:0] addr [NSLV];

  logic [ADDR_W-1:0] m_addr [NSLV];
  logic [NSLV-1:0]   m_pass;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  assign chain[0] = 1'b1;
  for (genvar g = 1; g < NSLV; g++) begin : g_link
    assign chain[g] = pass[g-1];
  end

  for (genvar g = 0; g < NSLV; g++) begin : g_slv
    chain_addr_slave #(.ADDR_W(ADDR_W)) i_chain_addr_slave (
      .clk(clk), .rst_n(rst_n), .chain_in(chain[g]), .clr_all(clr_all),
      .assign_stb(assign_stb), .assign_val(assign_val), .enum_phase(enum_phase),
      .evt_pend(evt[g]), .my_addr(addr[g]), .bus_on(bus[g]), .pass_en(pass[g]),
      .irq_req(irq[g]));
  end

  function automatic logic exp_irq(logic [ADDR_W-1:0] a, logic ph, logic ev);
    return ev && (a != 0) && !ph;
  endfunction

  function automatic logic m_chain(int i);
    return (i == 0) ? 1'b1 : m_pass[i-1];
  endfunction

  task automatic chk(string req, int i, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s slave %0d actual=%0d expected=%0d", req, i, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < NSLV; i++) begin
      chk("R3/R4/R5/R6/R2 addr", i, addr[i], m_addr[i]);
      chk("R7 pass_en", i, pass[i], m_pass[i]);
      chk("R8 bus_on", i, bus[i], m_chain(i));
      chk("R9 irq_req", i, irq[i], exp_irq(m_addr[i], enum_phase, evt[i]));
    end
  endtask

  task automatic step();
    logic [ADDR_W-1:0] na [NSLV];
    logic [NSLV-1:0] np;
    for (int i = 0; i < NSLV; i++) begin
      na[i] = m_addr[i];
      if (clr_all) na[i] = '0;
      else if (assign_stb && m_chain(i) && m_addr[i] == 0 && assign_val != 0)
        na[i] = assign_val;
      np[i] = !clr_all && (m_addr[i] != 0) && m_chain(i);
    end
    for (int i = 0; i < NSLV; i++) m_addr[i] = na[i];
    m_pass = np;
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive(logic c, logic s, logic [ADDR_W-1:0] v, logic ph);
    clr_all = c; assign_stb = s; assign_val = v; enum_phase = ph;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    for (int i = 0; i < NSLV; i++) m_addr[i] = '0;
    m_pass = '0;
    repeat (2) @(negedge clk);
    // R1: reset state
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R10: directed sequential numbering 1..NSLV, with waits for the ripple
    enum_phase = 1'b1;
    for (int n = 1; n <= NSLV; n++) begin
      drive(1'b0, 1'b1, ADDR_W'(n), 1'b1);
      step();
      drive(1'b0, 1'b0, '0, 1'b1);
      step();
    end
    for (int i = 0; i < NSLV; i++) chk("R10 chain order", i, addr[i], i + 1);
    // R6: strobe once the whole chain is numbered changes nothing
    drive(1'b0, 1'b1, 5'd31, 1'b1);
    step();
    drive(1'b0, 1'b0, '0, 1'b0);
    evt = '1;
    step();
    for (int i = 0; i < NSLV; i++) chk("R6/R9 irq after phase", i, irq[i], 1);
    // R2: clear beats a simultaneous assignment
    drive(1'b1, 1'b1, 5'd7, 1'b1);
    step();
    chk("R2 clear priority", 0, addr[0], 0);
    chk("R2 pass cleared", 0, pass[0], 0);
    // R5: zero value ignored by the head slave
    drive(1'b0, 1'b1, 5'd0, 1'b1);
    step();
    chk("R5 zero ignored", 0, addr[0], 0);
    // R4: second slave blocked while head is unaddressed
    chk("R4 downstream blocked", 1, bus[1], 0);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic c;
      c = ($urandom_range(0, 199) == 0);
      drive(c, $urandom_range(0, 1) == 1, ADDR_W'($urandom_range(0, 31)),
            $urandom_range(0, 3) != 0);
      evt = NSLV'({$urandom(), $urandom()});
      step();
    end
    drive(1'b0, 1'b0, '0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule